// File: doc/BRIEF.md
# Dual-output waveform timer channel

This block is one timer channel running in waveform mode. A single 16-bit up-counter advances on a selectable tick and wraps to zero when it reaches the period compare value. Two outputs, A and B, share this counter and this period. Each output has its own duty compare value. Each output also has three two-bit action fields: one for its duty match, one for the period match and one for a software trigger. Each field sets, clears or toggles the output, or leaves it alone. Software sets up the mode word, the three compare values and a command word through a small write/read register port.

A typical setup for a PWM of normal polarity programs "set" on the period match, "clear" on the duty match and "set" on the software trigger. The channel is then started with clock-enable and software-trigger in one command write. For 0% or 100% duty, software leaves the compare actions at "none" and picks the level with the software-trigger action alone. The level then stays constant while the counter runs.

Top module: `wave_timer_channel`

## Requirements
- R1: After reset the mode word, the three compare values and the counter read as zero, the counter is stopped, and both outputs are low.
- R2: Register addresses: 0 = mode, 1 = duty compare A, 2 = duty compare B, 3 = period compare, 4 = command (write-only, reads 0), 5 = counter (read-only). Addresses 6 and 7 read 0. A written value is returned by a read of the same address.
- R3: While the counter runs, each tick moves it up by one. A tick whose incremented value equals the period compare value is a period match, and the counter goes to 0 on that tick. The counter therefore cycles through 0 to P-1, so the period is P ticks.
- R4: Mode bits [2:0] select the tick. Values 0, 1, 2 and 3 give one tick every 1, 4, 16 and 64 clock cycles; this prescaler is restarted by the software trigger. Value 4 takes one tick per cycle in which the slow-tick input is high. Values 5 to 7 give no ticks.
- R5: A duty match is a tick whose incremented counter value equals that output's duty value. With "set" on period match, "clear" on duty match and "set" on trigger, output A is high for D of every P ticks, and it is high exactly when the counter is below D. With the three actions swapped, output A is high for P-D ticks, exactly when the counter is at or above D.
- R6: Output B behaves the same way, using duty compare B and mode bits [15:10]. Rewriting only the B fields leaves output A unchanged.
- R7: Action codes: 0 = none, 1 = set, 2 = clear, 3 = toggle. Mode bits [5:4], [7:6] and [9:8] hold A's duty, period and trigger actions. Bits [11:10], [13:12] and [15:14] hold the same three actions for B.
- R8: When a period match and a duty match fall on the same tick, the period-match action is applied.
- R9: A software trigger applies each output's trigger action at the next clock edge and sets the counter to 0 at that edge. It takes precedence over any match in the same cycle.
- R10: With both compare actions set to "none", an output keeps the level left by its trigger action while the counter runs.
- R11: Command bits are write-one pulses: bit 0 starts the counter, bit 1 stops it and bit 2 is the software trigger. Stop wins over start when both are written together. Writing stop together with trigger leaves the counter held at 0.
- R12: With mode bit 3 (waveform mode) at 0, the counter does not count and neither output changes, not even on a software trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | Slow tick pulse, one cycle per slow period, synchronous to clk |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for regAddr (combinational) |
| pwmA | output | 1 | Waveform output A |
| pwmB | output | 1 | Waveform output B |

## Verification
Some rules are checked on every cycle. The software trigger always returns the counter to zero and wins over matches. A period match wins over a duty match. The counter is frozen while stopped. An output never moves without an event. Stop wins over start. The duty ratio, the polarity, the tick rate of each clock-select value and the independence of the two outputs only show over whole periods. Only the bench's scenarios can show those, by counting high cycles against the counter value read through the register port.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_SET    = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  // per-output action set; field order fixed by the mode word layout
  typedef struct packed {
    act_e onSw;
    act_e onPeriod;
    act_e onDuty;
  } outCfg_t;

  typedef struct packed {
    outCfg_t    cfgB;      // [15:10]
    outCfg_t    cfgA;      // [9:4]
    logic       waveMode;  // [3]
    logic [2:0] clkSel;    // [2:0]
  } modeCfg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic swTrig;
    logic countEn;
    logic waveMode;
  } dpStrobe_t;

  localparam int MODE_W = $bits(modeCfg_t);
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY_A = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY_B = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CMD    = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd5;

  localparam int CMD_EN_BIT  = 0;
  localparam int CMD_DIS_BIT = 1;
  localparam int CMD_SW_BIT  = 2;

  function automatic logic applyAct(input act_e act, input logic cur);
    case (act)
      ACT_SET:    return 1'b1;
      ACT_CLEAR:  return 1'b0;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/wtc_outstage.sv
module wtc_outstage
  import wtc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  outCfg_t cfg,
  input  logic    waveMode,
  input  logic    swTrig,
  input  logic    periodHit,
  input  logic    dutyHit,
  output logic    pwmOut
);

  logic levelQ;

  // trigger > period match > duty match
  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= 1'b0;
    end else if (waveMode) begin
      if (swTrig)         levelQ <= applyAct(cfg.onSw, levelQ);
      else if (periodHit) levelQ <= applyAct(cfg.onPeriod, levelQ);
      else if (dutyHit)   levelQ <= applyAct(cfg.onDuty, levelQ);
    end
  end

  assign pwmOut = levelQ;

  AST_TRIG_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (waveMode && swTrig && cfg.onSw == ACT_SET) |=> pwmOut); // R9

  AST_TRIG_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (waveMode && swTrig && cfg.onSw == ACT_CLEAR) |=> !pwmOut); // R9

  AST_PERIOD_BEATS_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (waveMode && !swTrig && periodHit && dutyHit && cfg.onPeriod == ACT_SET) |=> pwmOut); // R8

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!swTrig && !periodHit && !dutyHit) |=> $stable(pwmOut)); // R10

  AST_NO_WAVE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!waveMode) |=> $stable(pwmOut)); // R12

endmodule

// File: rtl/wtc_datapath.sv
module wtc_datapath
  import wtc_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int NUM_DIV    = 4,
  parameter int PRESC_STEP = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slowTick,
  input  dpStrobe_t        strobe,
  input  modeCfg_t         modeCfg,
  input  logic [CNT_W-1:0] dutyA,
  input  logic [CNT_W-1:0] dutyB,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cntVal,
  output logic [1:0]       pwmOut
);

  localparam int         PRE_W    = PRESC_STEP * (NUM_DIV - 1);
  localparam logic [2:0] SLOW_SEL = 3'(NUM_DIV);
  localparam int         NUM_OUT  = 2;

  logic [PRE_W-1:0]   preCnt;
  logic [NUM_DIV-1:0] divTick;
  logic               selTick;
  logic               tick;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cntNext;
  logic               periodHit;
  logic [CNT_W-1:0]   dutyVec [NUM_OUT];
  outCfg_t            cfgVec  [NUM_OUT];
  logic [NUM_OUT-1:0] dutyHit;

  // free-running prescaler, realigned by the software trigger
  always_ff @(posedge clk) begin
    if (!rstN)              preCnt <= '0;
    else if (strobe.swTrig) preCnt <= '0;
    else                    preCnt <= preCnt + PRE_W'(1);
  end

  generate
    for (genvar k = 0; k < NUM_DIV; k++) begin : gDiv
      if (k == 0) begin : gFull
        assign divTick[k] = 1'b1;
      end else begin : gPre
        assign divTick[k] = &preCnt[PRESC_STEP*k-1:0];
      end
    end
  endgenerate

  always_comb begin
    selTick = 1'b0;
    for (int k = 0; k < NUM_DIV; k++) begin
      if (modeCfg.clkSel == 3'(k)) selTick = divTick[k];
    end
    if (modeCfg.clkSel == SLOW_SEL) selTick = slowTick;
  end

  assign tick      = strobe.countEn && selTick;
  assign cntNext   = cnt + CNT_W'(1);
  assign periodHit = tick && (cntNext == period);

  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.swTrig) cnt <= '0;
    else if (tick)          cnt <= periodHit ? '0 : cntNext;
  end

  assign cntVal = cnt;

  assign dutyVec[0] = dutyA;
  assign dutyVec[1] = dutyB;
  assign cfgVec[0]  = modeCfg.cfgA;
  assign cfgVec[1]  = modeCfg.cfgB;

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : gOut
      assign dutyHit[g] = tick && (cntNext == dutyVec[g]);
      wtc_outstage uOut (
        .clk      (clk),
        .rstN     (rstN),
        .cfg      (cfgVec[g]),
        .waveMode (strobe.waveMode),
        .swTrig   (strobe.swTrig),
        .periodHit(periodHit),
        .dutyHit  (dutyHit[g]),
        .pwmOut   (pwmOut[g])
      );
    end
  endgenerate

  AST_TRIG_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swTrig |=> (cnt == '0)); // R9

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (periodHit && !strobe.swTrig) |=> (cnt == '0)); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !periodHit && !strobe.swTrig) |=> (cnt == $past(cnt) + CNT_W'(1))); // R3

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !strobe.swTrig) |=> $stable(cnt)); // R11

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  input  logic [CNT_W-1:0]  cntVal,
  output logic [BUS_W-1:0]  regRdata,
  output modeCfg_t          modeCfg,
  output logic [CNT_W-1:0]  dutyA,
  output logic [CNT_W-1:0]  dutyB,
  output logic [CNT_W-1:0]  period,
  output dpStrobe_t         strobe
);

  modeCfg_t         modeReg;
  logic [CNT_W-1:0] dutyAReg;
  logic [CNT_W-1:0] dutyBReg;
  logic [CNT_W-1:0] periodReg;
  logic             clkRun;
  logic             cmdWr;
  logic             cmdEn;
  logic             cmdDis;
  logic             cmdSw;

  assign cmdWr  = regWr && (regAddr == ADDR_CMD);
  assign cmdEn  = cmdWr && regWdata[CMD_EN_BIT];
  assign cmdDis = cmdWr && regWdata[CMD_DIS_BIT];
  assign cmdSw  = cmdWr && regWdata[CMD_SW_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg   <= '0;
      dutyAReg  <= '0;
      dutyBReg  <= '0;
      periodReg <= '0;
    end else if (regWr) begin
      case (regAddr)
        ADDR_MODE:   modeReg   <= modeCfg_t'(regWdata[MODE_W-1:0]);
        ADDR_DUTY_A: dutyAReg  <= regWdata[CNT_W-1:0];
        ADDR_DUTY_B: dutyBReg  <= regWdata[CNT_W-1:0];
        ADDR_PERIOD: periodReg <= regWdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // stop dominates start
  always_ff @(posedge clk) begin
    if (!rstN)      clkRun <= 1'b0;
    else if (cmdDis) clkRun <= 1'b0;
    else if (cmdEn)  clkRun <= 1'b1;
  end

  always_comb begin
    case (regAddr)
      ADDR_MODE:   regRdata = BUS_W'(modeReg);
      ADDR_DUTY_A: regRdata = BUS_W'(dutyAReg);
      ADDR_DUTY_B: regRdata = BUS_W'(dutyBReg);
      ADDR_PERIOD: regRdata = BUS_W'(periodReg);
      ADDR_COUNT:  regRdata = BUS_W'(cntVal);
      default:     regRdata = '0;
    endcase
  end

  assign modeCfg         = modeReg;
  assign dutyA           = dutyAReg;
  assign dutyB           = dutyBReg;
  assign period          = periodReg;
  assign strobe.swTrig   = cmdSw;
  assign strobe.countEn  = clkRun && modeReg.waveMode;
  assign strobe.waveMode = modeReg.waveMode;

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cmdDis |=> !clkRun); // R11

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEn && !cmdDis) |=> clkRun); // R11

  AST_RUN_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWr) |=> $stable(clkRun)); // R11

endmodule

// File: rtl/wave_timer_channel.sv
module wave_timer_channel
  import wtc_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int NUM_DIV    = 4,
  parameter int PRESC_STEP = 2,
  localparam int BUS_W     = (CNT_W > MODE_W) ? CNT_W : MODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  output logic              pwmA,
  output logic              pwmB
);

  modeCfg_t         modeCfg;
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] dutyA;
  logic [CNT_W-1:0] dutyB;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cntVal;
  logic [1:0]       pwmOut;

  wtc_ctrl #(.CNT_W(CNT_W), .BUS_W(BUS_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .cntVal  (cntVal),
    .regRdata(regRdata),
    .modeCfg (modeCfg),
    .dutyA   (dutyA),
    .dutyB   (dutyB),
    .period  (period),
    .strobe  (strobe)
  );

  wtc_datapath #(.CNT_W(CNT_W), .NUM_DIV(NUM_DIV), .PRESC_STEP(PRESC_STEP)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .slowTick(slowTick),
    .strobe  (strobe),
    .modeCfg (modeCfg),
    .dutyA   (dutyA),
    .dutyB   (dutyB),
    .period  (period),
    .cntVal  (cntVal),
    .pwmOut  (pwmOut)
  );

  assign pwmA = pwmOut[0];
  assign pwmB = pwmOut[1];

endmodule

// File: tb/wave_timer_channel_test.sv
module wave_timer_channel_test;

  localparam int CLK_PERIOD = 10;
  localparam int A_NONE = 0, A_SET = 1, A_CLR = 2, A_TGL = 3;
  localparam int NV = 6;
  // {duty, period, inverted}
  localparam int VEC [NV][3] = '{'{2, 8, 0}, '{5, 8, 0}, '{1, 4, 0},
                                 '{3, 10, 1}, '{7, 9, 1}, '{4, 5, 0}};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd5;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        pwmA, pwmB;

  int checks = 0;
  int fails = 0;

  wave_timer_channel uut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .pwmA(pwmA), .pwmB(pwmB)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkMode(input int sel, input int wave,
      input int aDuty, input int aPer, input int aSw,
      input int bDuty, input int bPer, input int bSw);
    return {bSw[1:0], bPer[1:0], bDuty[1:0], aSw[1:0], aPer[1:0], aDuty[1:0], wave[0], sel[2:0]};
  endfunction

  // called just after a falling edge; returns just after the next one
  task automatic wr(input int a, input int d);
    regWr = 1'b1; regAddr = a[2:0]; regWdata = d[15:0];
    @(negedge clk);
    regWr = 1'b0; regAddr = 3'd5;
  endtask

  task automatic rdChk(input int a, input int exp, input string req);
    regAddr = a[2:0];
    #1;
    chk(int'(regRdata) == exp, req, int'(regRdata), exp);
    regAddr = 3'd5;
    #1;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int hi, bad, cntNow, aHi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) rdChk(a, 0, "R1 reg after reset");
    chk(pwmA == 1'b0 && pwmB == 1'b0, "R1 outputs low", {pwmA, pwmB}, 0);
    waitN(5);
    rdChk(5, 0, "R1 counter stopped");

    // R2 register readback
    wr(1, 1234); wr(2, 16'h0BCD); wr(3, 16'hFFF0); wr(0, 16'h5A30);
    rdChk(0, 16'h5A30, "R2 mode");
    rdChk(1, 1234, "R2 duty A");
    rdChk(2, 16'h0BCD, "R2 duty B");
    rdChk(3, 16'hFFF0, "R2 period");
    rdChk(4, 0, "R2 command reads 0");
    rdChk(6, 0, "R2 unused address");

    // R3 R5 R7 vector table: PWM ratio and polarity on output A
    for (int v = 0; v < NV; v++) begin
      int d = VEC[v][0];
      int p = VEC[v][1];
      int inv = VEC[v][2];
      int expHi = inv ? (p - d) : d;
      wr(3, p); wr(1, d);
      if (inv) wr(0, mkMode(0, 1, A_SET, A_CLR, A_CLR, 0, 0, 0));
      else     wr(0, mkMode(0, 1, A_CLR, A_SET, A_SET, 0, 0, 0));
      wr(4, 5);
      hi = 0; bad = 0;
      for (int k = 0; k < 2 * p; k++) begin
        cntNow = int'(regRdata);
        if (cntNow != (k % p)) bad++;
        if (pwmA != (inv ? (cntNow >= d) : (cntNow < d))) bad++;
        hi += pwmA;
        @(negedge clk);
      end
      chk(hi == 2 * expHi, "R5 high ticks over two periods", hi, 2 * expHi);
      chk(bad == 0, "R3 counter/output sequence mismatches", bad, 0);
    end

    // R7 toggle on period match
    wr(3, 4);
    wr(0, mkMode(0, 1, A_NONE, A_TGL, A_CLR, 0, 0, 0));
    wr(4, 5);
    chk(pwmA == 1'b0, "R7 trigger clear", pwmA, 0);
    waitN(4);
    chk(pwmA == 1'b1, "R7 toggle first wrap", pwmA, 1);
    waitN(4);
    chk(pwmA == 1'b0, "R7 toggle second wrap", pwmA, 0);

    // R8 duty == period: period action wins
    wr(3, 5); wr(1, 5);
    wr(0, mkMode(0, 1, A_CLR, A_SET, A_CLR, 0, 0, 0));
    wr(4, 5);
    waitN(4);
    chk(pwmA == 1'b0, "R8 before coincident match", pwmA, 0);
    waitN(1);
    chk(pwmA == 1'b1, "R8 period beats duty", pwmA, 1);
    waitN(5);
    chk(pwmA == 1'b1, "R8 stays set", pwmA, 1);

    // R9 trigger coincides with period match
    wr(3, 3);
    wr(0, mkMode(0, 1, A_NONE, A_SET, A_CLR, 0, 0, 0));
    wr(4, 5);
    waitN(2);
    wr(4, 4);
    chk(pwmA == 1'b0, "R9 trigger beats period match", pwmA, 0);
    rdChk(5, 0, "R9 counter restarted");
    waitN(3);
    chk(pwmA == 1'b1, "R9 period set after restart", pwmA, 1);

    // R10 constant low / high with no compare actions
    wr(3, 5);
    wr(0, mkMode(0, 1, A_NONE, A_NONE, A_CLR, 0, 0, 0));
    wr(4, 5);
    hi = 0; bad = 0;
    for (int k = 0; k < 15; k++) begin
      hi += pwmA;
      if (int'(regRdata) != 0) bad++;
      @(negedge clk);
    end
    chk(hi == 0, "R10 held low", hi, 0);
    chk(bad > 0, "R10 counter runs meanwhile", bad, 12);
    wr(0, mkMode(0, 1, A_NONE, A_NONE, A_SET, 0, 0, 0));
    wr(4, 4);
    hi = 0;
    for (int k = 0; k < 15; k++) begin hi += pwmA; @(negedge clk); end
    chk(hi == 15, "R10 held high", hi, 15);

    // R6 output B independent of A
    wr(3, 6); wr(2, 2);
    wr(0, mkMode(0, 1, A_NONE, A_NONE, A_SET, A_CLR, A_SET, A_SET));
    wr(4, 5);
    hi = 0; aHi = 0;
    for (int k = 0; k < 12; k++) begin hi += pwmB; aHi += pwmA; @(negedge clk); end
    chk(hi == 4, "R6 B high ticks", hi, 4);
    chk(aHi == 12, "R6 A held while B runs", aHi, 12);
    wr(0, mkMode(0, 1, A_NONE, A_NONE, A_SET, A_SET, A_CLR, A_CLR));
    aHi = 0;
    for (int k = 0; k < 12; k++) begin aHi += pwmA; @(negedge clk); end
    chk(aHi == 12, "R6 A unchanged by B field rewrite", aHi, 12);

    // R4 tick selection
    wr(3, 1000);
    wr(0, mkMode(1, 1, 0, 0, 0, 0, 0, 0)); wr(4, 5);
    waitN(40); rdChk(5, 10, "R4 divide by 4");
    wr(0, mkMode(2, 1, 0, 0, 0, 0, 0, 0)); wr(4, 5);
    waitN(64); rdChk(5, 4, "R4 divide by 16");
    wr(0, mkMode(3, 1, 0, 0, 0, 0, 0, 0)); wr(4, 5);
    waitN(128); rdChk(5, 2, "R4 divide by 64");
    wr(0, mkMode(4, 1, 0, 0, 0, 0, 0, 0)); wr(4, 5);
    for (int k = 0; k < 5; k++) begin
      slowTick = 1'b1; @(negedge clk); slowTick = 1'b0; waitN(2);
    end
    rdChk(5, 5, "R4 slow tick count");
    wr(0, mkMode(5, 1, 0, 0, 0, 0, 0, 0)); wr(4, 5);
    waitN(20); rdChk(5, 0, "R4 reserved select no ticks");

    // R11 command pulses
    wr(0, mkMode(0, 1, 0, 0, 0, 0, 0, 0)); wr(4, 5);
    waitN(5);
    wr(4, 3);
    waitN(10); rdChk(5, 6, "R11 stop wins over start");
    wr(4, 6);
    waitN(10); rdChk(5, 0, "R11 stop with trigger holds 0");
    wr(4, 1);
    waitN(3); rdChk(5, 3, "R11 start resumes");

    // R12 waveform mode off
    wr(0, mkMode(0, 1, 0, 0, A_CLR, 0, 0, A_CLR)); wr(4, 4);
    wr(0, mkMode(0, 0, 0, 0, A_SET, 0, 0, A_SET)); wr(4, 5);
    waitN(10);
    rdChk(5, 0, "R12 counter idle");
    chk(pwmA == 1'b0 && pwmB == 1'b0, "R12 trigger ignored", {pwmA, pwmB}, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule